// File: doc/BRIEF.md
# Byte/Word Configurable Parallel ROM Read Controller

This block sits on the host side of an asynchronous parallel read-only memory and turns one-cycle read requests into correctly timed pin activity. The memory can be wired 16 bits wide or 8 bits wide. A strap pin selects the width, and one pin changes its role with it. In the 16-bit organisation that pin carries data bit 15 and the controller leaves it undriven. In the 8-bit organisation it is the lowest byte address, which the controller drives to pick the lower or the upper half of the logical 16-bit word.

A request carries a word address, a mode and a half select. The controller lowers chip select and output enable together and holds the address steady. It waits a parameterised number of clock cycles, computed by rounding the memory's access times up to whole clock periods, and then captures the data. For a byte-pair request it reads the lower byte first, then flips the byte-address pin, waits a second full access window, and returns the joined 16-bit word with a single response strobe. After every transaction chip select returns high so the memory rests in standby. The controller then refuses new work for a bus-release interval, which gives the memory's outputs time to float.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: After reset and while idle: `mem_ce_n`=1, `mem_oe_n`=1, `mem_word_sel`=1, `mem_pin15_oe`=0, `req_ready`=1 and `rsp_valid`=0.
- R2: Mode 0 (16-bit read; the unused code 3 behaves the same) keeps `mem_word_sel`=1 and `mem_pin15_oe`=0 during the access. It returns `rsp_data` = {`mem_pin15_in`, `mem_d_in[14:0]`}.
- R3: Mode 1 (single byte) drives `mem_word_sel`=0 and `mem_pin15_oe`=1, with `mem_pin15_out` = `req_hi` (0 = lower half, 1 = upper half). It returns `rsp_data` = {8'h00, `mem_d_in[7:0]`}.
- R4: Mode 2 (byte pair) performs two byte accesses at one word address, first with `mem_pin15_out`=0 and then with `mem_pin15_out`=1. It raises `rsp_valid` once, with `rsp_data` = {second byte, first byte}.
- R5: `rsp_valid` rises exactly ACC_CYC clock edges after the accepting edge (2·ACC_CYC for mode 2). ACC_CYC is the largest of the address, select, output-enable and width-select delays divided by the clock period, rounded up. Address and byte-address pin stay constant throughout each access window.
- R6: During an access `mem_ce_n` and `mem_oe_n` are both low. `mem_oe_n` is never low while `mem_ce_n` is high.
- R7: `mem_ce_n` and `mem_oe_n` return high on the same edge that raises `rsp_valid`. `rsp_valid` lasts one cycle.
- R8: After a response `req_ready` stays low for exactly FLOAT_CYC cycles, where FLOAT_CYC is the output-release delay rounded up to whole cycles. `mem_ce_n` is high for at least FLOAT_CYC cycles before every new access.
- R9: A request presented while `req_ready` is low is ignored. The pins keep the accepted address, and the response belongs to the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | ADDR_W | Word address |
| req_mode | input | 2 | 0 word, 1 single byte, 2 byte pair, 3 treated as word |
| req_hi | input | 1 | Half select for single-byte mode |
| req_ready | output | 1 | Controller can take a request |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 16 | Response data |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_word_sel | output | 1 | Width strap: 1 = 16-bit, 0 = 8-bit |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_pin15_out | output | 1 | Byte-address value for the dual-role pin |
| mem_pin15_oe | output | 1 | Drive enable for the dual-role pin |
| mem_pin15_in | input | 1 | Data bit 15 read from the dual-role pin |
| mem_d_in | input | 15 | Data bits 14..0 from the memory |

## Verification
On every cycle the assertions check the pin protocol. Output enable never leads chip select, the address holds while selected, the dual-role pin is never driven while the part is deselected, and every response comes after a full access window. They also check that each new select follows the release gap. Which byte lands in which half, the zero fill of single-byte reads, the exact response latency and the discarding of requests made while busy show only in the bench's sweeps. Those sweeps run against a memory model that returns junk whenever its timing is violated.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

    typedef enum logic [1:0] {
        MODE_WORD = 2'd0,
        MODE_BYTE = 2'd1,
        MODE_PAIR = 2'd2
    } rd_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACCESS  = 2'd1,
        ST_RECOVER = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic ce;
        logic oe;
        logic byte_mode;
        logic a1;
    } bus_ctl_t;

    function automatic int ns_to_cycles(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    function automatic rd_mode_e decode_mode(input logic [1:0] code);
        case (code)
            2'd1:    return MODE_BYTE;
            2'd2:    return MODE_PAIR;
            default: return MODE_WORD;
        endcase
    endfunction

endpackage

// File: rtl/eprom_rd_timer.sv
module eprom_rd_timer #(
    parameter int TW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          zero
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/eprom_rd_seq.sv
module eprom_rd_seq
    import eprom_rd_pkg::*;
#(
    parameter int ADDR_W    = 21,
    parameter int TW        = 5,
    parameter int ACC_CYC   = 25,
    parameter int FLOAT_CYC = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_mode,
    input  logic              req_hi,
    output logic              req_ready,
    output logic              tmr_load,
    output logic [TW-1:0]     tmr_val,
    input  logic              tmr_zero,
    output bus_ctl_t          ctl,
    output logic [ADDR_W-1:0] addr_q,
    output rd_mode_e          mode_q,
    output logic              cap_lo,
    output logic              cap_fin
);
    localparam logic [TW-1:0] ACC_LOAD   = TW'(ACC_CYC - 1);
    localparam logic [TW-1:0] FLOAT_LOAD = TW'(FLOAT_CYC - 1);

    seq_state_e state;
    logic       phase;
    logic       accept;
    logic       acc_done;
    logic       pair_first;
    rd_mode_e   mode_in;

    assign mode_in    = decode_mode(req_mode);
    assign req_ready  = (state == ST_IDLE);
    assign accept     = req_valid && req_ready;
    assign acc_done   = (state == ST_ACCESS) && tmr_zero;
    assign pair_first = (mode_q == MODE_PAIR) && !phase;
    assign cap_lo     = acc_done && pair_first;
    assign cap_fin    = acc_done && !pair_first;
    assign tmr_load   = accept || acc_done;
    assign tmr_val    = (accept || cap_lo) ? ACC_LOAD : FLOAT_LOAD;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            phase  <= 1'b0;
            mode_q <= MODE_WORD;
            addr_q <= '0;
            ctl    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state         <= ST_ACCESS;
                        phase         <= 1'b0;
                        mode_q        <= mode_in;
                        addr_q        <= req_addr;
                        ctl.ce        <= 1'b1;
                        ctl.oe        <= 1'b1;
                        ctl.byte_mode <= (mode_in != MODE_WORD);
                        ctl.a1        <= (mode_in == MODE_BYTE) ? req_hi : 1'b0;
                    end
                end
                ST_ACCESS: begin
                    if (cap_lo) begin
                        phase  <= 1'b1;
                        ctl.a1 <= 1'b1;
                    end else if (cap_fin) begin
                        state <= ST_RECOVER;
                        ctl   <= '0;
                    end
                end
                ST_RECOVER: begin
                    if (tmr_zero) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/eprom_rd_capture.sv
module eprom_rd_capture
    import eprom_rd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cap_lo,
    input  logic        cap_fin,
    input  rd_mode_e    mode,
    input  logic [14:0] d_in,
    input  logic        pin15_in,
    output logic        rsp_valid,
    output logic [15:0] rsp_data
);
    logic [7:0]  lo_q;
    logic [15:0] joined;

    always_comb begin
        case (mode)
            MODE_BYTE: joined = {8'h00, d_in[7:0]};
            MODE_PAIR: joined = {d_in[7:0], lo_q};
            default:   joined = {pin15_in, d_in};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            lo_q      <= '0;
        end else begin
            rsp_valid <= cap_fin;
            if (cap_lo)  lo_q     <= d_in[7:0];
            if (cap_fin) rsp_data <= joined;
        end
    end
endmodule

// File: rtl/eprom_rd_pins.sv
module eprom_rd_pins
    import eprom_rd_pkg::*;
(
    input  bus_ctl_t ctl,
    output logic     ce_n,
    output logic     oe_n,
    output logic     word_sel,
    output logic     pin15_out,
    output logic     pin15_oe
);
    assign ce_n      = !ctl.ce;
    assign oe_n      = !(ctl.oe && ctl.ce);
    assign word_sel  = !ctl.byte_mode;
    assign pin15_oe  = ctl.byte_mode;
    assign pin15_out = ctl.a1;
endmodule

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl
    import eprom_rd_pkg::*;
#(
    parameter int ADDR_W        = 21,
    parameter int CLK_PERIOD_NS = 4,
    parameter int T_ADDR_NS     = 100,
    parameter int T_CE_NS       = 100,
    parameter int T_OE_NS       = 45,
    parameter int T_WSEL_NS     = 100,
    parameter int T_FLOAT_NS    = 45
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_mode,
    input  logic              req_hi,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [15:0]       rsp_data,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_word_sel,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_pin15_out,
    output logic              mem_pin15_oe,
    input  logic              mem_pin15_in,
    input  logic [14:0]       mem_d_in
);
    localparam int ACC_CYC   = ns_to_cycles(max_of4(T_ADDR_NS, T_CE_NS, T_OE_NS, T_WSEL_NS),
                                            CLK_PERIOD_NS);
    localparam int FLOAT_CYC = ns_to_cycles(T_FLOAT_NS, CLK_PERIOD_NS);
    localparam int MAX_CYC   = (ACC_CYC > FLOAT_CYC) ? ACC_CYC : FLOAT_CYC;
    localparam int TW        = $clog2(MAX_CYC + 1);

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;
    bus_ctl_t      ctl;
    rd_mode_e      mode_q;
    logic          cap_lo;
    logic          cap_fin;

    eprom_rd_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    eprom_rd_seq #(
        .ADDR_W    (ADDR_W),
        .TW        (TW),
        .ACC_CYC   (ACC_CYC),
        .FLOAT_CYC (FLOAT_CYC)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_mode  (req_mode),
        .req_hi    (req_hi),
        .req_ready (req_ready),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .tmr_zero  (tmr_zero),
        .ctl       (ctl),
        .addr_q    (mem_addr),
        .mode_q    (mode_q),
        .cap_lo    (cap_lo),
        .cap_fin   (cap_fin)
    );

    eprom_rd_capture u_capture (
        .clk       (clk),
        .rst       (rst),
        .cap_lo    (cap_lo),
        .cap_fin   (cap_fin),
        .mode      (mode_q),
        .d_in      (mem_d_in),
        .pin15_in  (mem_pin15_in),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    eprom_rd_pins u_pins (
        .ctl       (ctl),
        .ce_n      (mem_ce_n),
        .oe_n      (mem_oe_n),
        .word_sel  (mem_word_sel),
        .pin15_out (mem_pin15_out),
        .pin15_oe  (mem_pin15_oe)
    );
endmodule

// File: rtl/eprom_rd_checker.sv
module eprom_rd_checker #(
    parameter int ADDR_W    = 21,
    parameter int ACC_CYC   = 25,
    parameter int FLOAT_CYC = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_pin15_out,
    input logic              mem_pin15_oe
);
    logic              armed;
    logic              last_ce_n;
    logic [ADDR_W+1:0] key_q;
    logic [ADDR_W+1:0] key;
    logic [15:0]       acc_cnt;
    logic [15:0]       hi_cnt;

    assign key = {mem_ce_n, mem_pin15_out & mem_pin15_oe, mem_addr};

    always_ff @(posedge clk) begin
        if (rst) begin
            armed     <= 1'b0;
            last_ce_n <= 1'b1;
            key_q     <= '0;
            acc_cnt   <= '0;
            hi_cnt    <= 16'(FLOAT_CYC);
        end else begin
            armed     <= 1'b1;
            last_ce_n <= mem_ce_n;
            key_q     <= key;
            if (!mem_ce_n)
                acc_cnt <= (key == key_q && acc_cnt != 16'hFFFF) ? acc_cnt + 16'd1 : 16'd1;
            else
                acc_cnt <= '0;
            if (mem_ce_n)
                hi_cnt <= (hi_cnt != 16'hFFFF) ? hi_cnt + 16'd1 : hi_cnt;
            else
                hi_cnt <= '0;
        end
    end

    AST_IDLE_UNDRIVEN: assert property (@(posedge clk) disable iff (rst)
        mem_ce_n |-> !mem_pin15_oe); // R1

    AST_OE_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !mem_ce_n); // R6

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (armed && !mem_ce_n && !last_ce_n) |-> $stable(mem_addr)); // R5

    AST_ACCESS_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (armed && rsp_valid) |-> (acc_cnt >= 16'(ACC_CYC))); // R5

    AST_STANDBY_AT_RSP: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (mem_ce_n && mem_oe_n)); // R7

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R7

    AST_RECOVERY_GAP: assert property (@(posedge clk) disable iff (rst)
        (armed && !mem_ce_n && last_ce_n) |-> (hi_cnt >= 16'(FLOAT_CYC))); // R8

    AST_READY_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> mem_ce_n); // R9
endmodule

bind eprom_rd_ctrl eprom_rd_checker #(
    .ADDR_W    (ADDR_W),
    .ACC_CYC   (ACC_CYC),
    .FLOAT_CYC (FLOAT_CYC)
) u_checker (
    .clk           (clk),
    .rst           (rst),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .mem_ce_n      (mem_ce_n),
    .mem_oe_n      (mem_oe_n),
    .mem_addr      (mem_addr),
    .mem_pin15_out (mem_pin15_out),
    .mem_pin15_oe  (mem_pin15_oe)
);

// File: tb/eprom_rd_ctrl_bench.sv
`timescale 1ns/1ps
module eprom_rd_ctrl_bench;
    localparam int ADDR_W    = 6;
    localparam int PERIOD    = 4;
    localparam int ACC_EXP   = (100 + PERIOD - 1) / PERIOD;
    localparam int FLOAT_EXP = (45 + PERIOD - 1) / PERIOD;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0]        req_mode = 2'd0;
    logic              req_hi = 1'b0;
    logic              req_ready;
    logic              rsp_valid;
    logic [15:0]       rsp_data;
    logic              mem_ce_n;
    logic              mem_oe_n;
    logic              mem_word_sel;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_pin15_out;
    logic              mem_pin15_oe;
    logic              mem_pin15_in;
    logic [14:0]       mem_d_in;

    int n_checks = 0;
    int n_fails  = 0;

    always #(PERIOD/2) clk = ~clk;

    eprom_rd_ctrl #(.ADDR_W(ADDR_W), .CLK_PERIOD_NS(PERIOD)) u_eprom_rd_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_mode(req_mode), .req_hi(req_hi), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_ce_n(mem_ce_n),
        .mem_oe_n(mem_oe_n), .mem_word_sel(mem_word_sel), .mem_addr(mem_addr),
        .mem_pin15_out(mem_pin15_out), .mem_pin15_oe(mem_pin15_oe),
        .mem_pin15_in(mem_pin15_in), .mem_d_in(mem_d_in)
    );

    // Memory model: returns stored data only after a full access window of
    // stable select, address, width strap and byte address; junk otherwise.
    function automatic logic [15:0] word_at(input int a);
        logic [15:0] v;
        v = 16'(a) * 16'h9E37 + 16'h1234;
        return v ^ (16'(a) << 9);
    endfunction

    logic [ADDR_W+2:0] mkey, mkey_q;
    int                stab = 0;
    logic              m_a1;
    logic              m_ok;
    logic [15:0]       m_word;

    assign m_a1   = mem_pin15_oe & mem_pin15_out;
    assign mkey   = {mem_ce_n, mem_word_sel, m_a1, mem_addr};
    assign m_ok   = !mem_ce_n && !mem_oe_n && (stab >= ACC_EXP - 1) && (mkey == mkey_q);
    assign m_word = word_at(int'(mem_addr));

    always @(posedge clk) begin
        mkey_q <= mkey;
        if (!mem_ce_n) stab <= (mkey == mkey_q) ? stab + 1 : 1;
        else           stab <= 0;
    end

    always_comb begin
        if (!m_ok) begin
            mem_d_in     = 15'h2AAA;
            mem_pin15_in = 1'b1;
        end else if (mem_word_sel) begin
            mem_d_in     = m_word[14:0];
            mem_pin15_in = m_word[15];
        end else begin
            mem_d_in     = {7'h7F, (m_a1 ? m_word[15:8] : m_word[7:0])};
            mem_pin15_in = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_read(input int a, input int m, input bit hi);
        logic [15:0] w, exp_d;
        int exp_lat, j, r;
        bit word_like;
        word_like = (m == 0 || m == 3);
        w = word_at(a);
        if (m == 1)      exp_d = {8'h00, (hi ? w[15:8] : w[7:0])};
        else             exp_d = w;
        exp_lat = (m == 2) ? 2 * ACC_EXP : ACC_EXP;

        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = ADDR_W'(a);
        req_mode  = 2'(m);
        req_hi    = hi;
        @(posedge clk);
        j = 0;
        do begin
            @(negedge clk);
            j++;
            if (j == 1) begin
                req_addr = ~ADDR_W'(a);   // request while busy must be ignored (R9)
                req_mode = 2'd1;
                req_hi   = ~hi;
            end
            if (j == 2) begin
                chk(!mem_ce_n && !mem_oe_n, "R6 select+enable low in access",
                    {mem_ce_n, mem_oe_n}, 0);
                chk(mem_addr == ADDR_W'(a), "R9 address held while busy request pending",
                    mem_addr, a);
                if (word_like)
                    chk(mem_word_sel && !mem_pin15_oe, "R2 word strap, pin15 undriven",
                        {mem_word_sel, mem_pin15_oe}, 2);
                else
                    chk(!mem_word_sel && mem_pin15_oe &&
                        mem_pin15_out == ((m == 1) ? hi : 1'b0),
                        "R3 byte strap, pin15 driven as byte address",
                        {mem_word_sel, mem_pin15_oe, mem_pin15_out},
                        {2'b01, ((m == 1) ? hi : 1'b0)});
            end
            if (m == 2 && j == ACC_EXP + 2)
                chk(mem_pin15_out && mem_pin15_oe && !mem_ce_n, "R4 second access on upper half",
                    {mem_pin15_oe, mem_pin15_out}, 3);
        end while (!rsp_valid && j < 400);
        req_valid = 1'b0;

        chk(rsp_valid && (j - 1) == exp_lat, "R5 response latency", j - 1, exp_lat);
        if (m == 2)      chk(rsp_data == exp_d, "R4 byte pair data", rsp_data, exp_d);
        else if (m == 1) chk(rsp_data == exp_d, "R3 single byte data", rsp_data, exp_d);
        else             chk(rsp_data == exp_d, "R2 word data", rsp_data, exp_d);
        chk(mem_ce_n && mem_oe_n && !req_ready, "R7 standby at response",
            {mem_ce_n, mem_oe_n, req_ready}, 6);

        r = 0;
        @(negedge clk);
        chk(!rsp_valid, "R7 response one cycle", rsp_valid, 0);
        while (!req_ready && r < 400) begin
            r++;
            @(negedge clk);
        end
        chk(r + 1 == FLOAT_EXP + 0 + 1 - 0 && r == FLOAT_EXP - 1 + 1 - 1 + 1 - 1 + 0 || r == FLOAT_EXP - 1,
            "R8 recovery length", r + 1, FLOAT_EXP);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_word_sel && !mem_pin15_oe && req_ready && !rsp_valid,
            "R1 reset state",
            {mem_ce_n, mem_oe_n, mem_word_sel, mem_pin15_oe, req_ready, rsp_valid}, 6'b111010);

        for (int a = 0; a < (1 << ADDR_W); a++) begin
            do_read(a, 0, 1'b0);
            do_read(a, 1, 1'b0);
            do_read(a, 1, 1'b1);
            do_read(a, 2, 1'b0);
            if (a % 8 == 5) do_read(a, 3, 1'b1);
        end

        @(negedge clk);
        chk(mem_ce_n && !mem_pin15_oe && req_ready, "R1 idle after sweep",
            {mem_ce_n, mem_pin15_oe, req_ready}, 5);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule